// File: doc/BRIEF.md
# Serial Data Output Controller

This block owns the serial data output of a small secured serial memory. The instruction decoder tells it when an opcode has been fully received and when a read-type transfer may begin. On a read start it takes the presented data word, sends it most significant bit first, and keeps sending words from consecutive addresses for as long as chip select stays high. The output enable goes low once chip select drops.

The block also reports self-timed program and erase cycles when the enable-busy state is set. In that case the output is driven low while the array timer reports busy. It switches high when the cycle ends and stays high until the next opcode has been received. A read start that arrives in that ready phase goes straight to data. Without the enable-busy state, the busy flag has no effect and the output stays undriven.

Words are either 16 or 8 bits wide, chosen by the organization input. An 8-bit word is taken from the low byte of the data bus. The array itself is not part of this block: its timing appears only as the busy input, and its data appears only as the word input.

Top module: `serial_dout_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, `dout_oe_o` is 0.
- R2: When `rd_go_i` is sampled high at a clock edge while the output is idle or in the ready phase, then from that edge on `dout_oe_o` is 1 and `dout_o` shows the first bit of `rd_word_i` as sampled at that edge.
- R3: Bits go out most significant first, one per clock. With `org_wide_i`=1 a word is bits 15..0 of `rd_word_i`. With `org_wide_i`=0 it is bits 7..0.
- R4: If `cs_i` is sampled low at any edge while a word is being sent, `dout_oe_o` is 0 after that edge. This includes the edge that ends the last bit.
- R5: If `cs_i` stays high through the edge that ends a word's last bit, that edge loads the next word from `rd_word_i` with no gap. `word_adv_o` is 1 for exactly the one cycle that follows every word load.
- R6: With `bsy_en_i`=1, sampling `busy_i`=1 while idle makes the block drive `dout_o`=0 with `dout_oe_o`=1 from the next cycle, for as long as busy stays high.
- R7: When `busy_i` is sampled low during that busy phase, `dout_o` becomes 1 after that edge. It stays driven high until `opc_done_i` or `rd_go_i` is sampled.
- R8: Sampling `opc_done_i`=1 in the ready phase, without `rd_go_i`, returns `dout_oe_o` to 0 after that edge.
- R9: With `bsy_en_i`=0, `busy_i` has no effect: `dout_oe_o` stays 0.
- R10: A read start sampled in the same cycle as the opcode-complete pulse, during the ready phase, starts data output at once. The read start takes precedence over the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| org_wide_i | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| opc_done_i | input | 1 | Pulse: opcode of an instruction fully received |
| rd_go_i | input | 1 | Pulse: start sending the word on rd_word_i |
| rd_word_i | input | 16 | Word at the current read address |
| busy_i | input | 1 | Program or erase cycle in progress |
| bsy_en_i | input | 1 | Busy reporting enabled |
| dout_o | output | 1 | Serial data output value |
| dout_oe_o | output | 1 | Output enable for the serial data pin |
| word_adv_o | output | 1 | One-cycle pulse after each word load: advance the read address |

## Verification
Every result in this block is one register stage from its cause. The first data bit, the low busy level, the high ready level and the return to high impedance all appear right after the clock edge that samples their cause. Data bit k of a word is visible after k further edges, and the next word's first bit follows the edge that ends the previous word's last bit. The bench changes inputs just after it samples, two time units past a rising edge. It checks each expected value in the cycle that edge arithmetic predicts, and counts bits and words itself rather than waiting on any output.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
   typedef enum logic [1:0] {
      SDO_IDLE  = 2'd0,
      SDO_SHIFT = 2'd1,
      SDO_BUSY  = 2'd2,
      SDO_READY = 2'd3
   } sdo_state_e;
endpackage

// File: rtl/sdo_shifter.sv
module sdo_shifter #(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8,
   localparam int CNT_W   = $clog2(WIDE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic              wide_i,
   input  logic [WIDE_W-1:0] word_i,
   output logic              bit_o,
   output logic              last_o
);
   localparam int PAD_W = WIDE_W - NARROW_W;

   logic [WIDE_W-1:0] sr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WIDE_W-1:0] load_val;
   logic [CNT_W-1:0]  load_cnt;

   initial begin
      assert (WIDE_W > NARROW_W) else $error("wide word must exceed narrow word");
      assert (NARROW_W > 1) else $error("narrow word too short");
   end

   always_comb begin
      if (wide_i) begin
         load_val = word_i;
         load_cnt = CNT_W'(WIDE_W - 1);
      end else begin
         load_val = {word_i[NARROW_W-1:0], {PAD_W{1'b0}}};
         load_cnt = CNT_W'(NARROW_W - 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         sr_q  <= load_val;
         cnt_q <= load_cnt;
      end else if (step_i) begin
         sr_q  <= {sr_q[WIDE_W-2:0], 1'b0};
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign bit_o  = sr_q[WIDE_W-1];
   assign last_o = (cnt_q == '0);

   AST_STEP_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !last_o) |=> (cnt_q == $past(cnt_q) - 1'b1)) // R3
      else $error("bit counter did not advance");

   AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !wide_i) |=> (cnt_q == CNT_W'(NARROW_W - 1))) // R3
      else $error("narrow word length wrong");
endmodule

// File: rtl/sdo_ctrl_fsm.sv
module sdo_ctrl_fsm
   import sdo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_i,
   input  logic       opc_done_i,
   input  logic       rd_go_i,
   input  logic       busy_i,
   input  logic       bsy_en_i,
   input  logic       last_i,
   output sdo_state_e state_o,
   output logic       load_o,
   output logic       step_o,
   output logic       adv_o
);
   sdo_state_e st_q, st_d;
   logic       adv_q;

   always_comb begin
      st_d   = st_q;
      load_o = 1'b0;
      step_o = 1'b0;
      unique case (st_q)
         SDO_IDLE: begin
            if (rd_go_i) begin
               st_d   = SDO_SHIFT;
               load_o = 1'b1;
            end else if (bsy_en_i && busy_i) begin
               st_d = SDO_BUSY;
            end
         end
         SDO_SHIFT: begin
            if (!cs_i) begin
               st_d = SDO_IDLE;
            end else if (last_i) begin
               load_o = 1'b1;
            end else begin
               step_o = 1'b1;
            end
         end
         SDO_BUSY: begin
            if (!busy_i) st_d = SDO_READY;
         end
         SDO_READY: begin
            if (rd_go_i) begin
               st_d   = SDO_SHIFT;
               load_o = 1'b1;
            end else if (opc_done_i) begin
               st_d = SDO_IDLE;
            end
         end
         default: st_d = SDO_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SDO_IDLE;
         adv_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         adv_q <= load_o;
      end
   end

   assign state_o = st_q;
   assign adv_o   = adv_q;

   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SDO_READY && !opc_done_i && !rd_go_i) |=> (st_q == SDO_READY)) // R7
      else $error("ready level not held");

   AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SDO_BUSY && busy_i) |=> (st_q == SDO_BUSY)) // R6
      else $error("busy phase left early");
endmodule

// File: rtl/serial_dout_ctrl.sv
module serial_dout_ctrl
   import sdo_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              org_wide_i,
   input  logic              opc_done_i,
   input  logic              rd_go_i,
   input  logic [WIDE_W-1:0] rd_word_i,
   input  logic              busy_i,
   input  logic              bsy_en_i,
   output logic              dout_o,
   output logic              dout_oe_o,
   output logic              word_adv_o
);
   sdo_state_e state;
   logic       load, step, sh_bit, sh_last;

   sdo_ctrl_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_i       (cs_i),
      .opc_done_i (opc_done_i),
      .rd_go_i    (rd_go_i),
      .busy_i     (busy_i),
      .bsy_en_i   (bsy_en_i),
      .last_i     (sh_last),
      .state_o    (state),
      .load_o     (load),
      .step_o     (step),
      .adv_o      (word_adv_o)
   );

   sdo_shifter #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .step_i (step),
      .wide_i (org_wide_i),
      .word_i (rd_word_i),
      .bit_o  (sh_bit),
      .last_o (sh_last)
   );

   always_comb begin
      unique case (state)
         SDO_SHIFT: dout_o = sh_bit;
         SDO_READY: dout_o = 1'b1;
         default:   dout_o = 1'b0;
      endcase
   end

   assign dout_oe_o = (state != SDO_IDLE);

   AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go_i && !dout_oe_o) |=> (dout_oe_o && dout_o == ($past(org_wide_i) ?
         $past(rd_word_i[WIDE_W-1]) : $past(rd_word_i[NARROW_W-1])))) // R2
      else $error("first bit wrong");

   AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SDO_SHIFT && !cs_i) |=> !dout_oe_o) // R4
      else $error("output kept after chip select dropped");

   AST_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && bsy_en_i && !dout_oe_o && !rd_go_i) |=> (dout_oe_o && !dout_o)) // R6
      else $error("busy not reported low");

   AST_NO_REPORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!dout_oe_o && !bsy_en_i && !rd_go_i) |=> !dout_oe_o) // R9
      else $error("drove output without enable");

   AST_DRIVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe_o) |-> ($past(rd_go_i) || $past(busy_i && bsy_en_i))) // R2
      else $error("output enabled without cause");
endmodule

// File: tb/serial_dout_ctrl_tb.sv
module serial_dout_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_i = 1'b0, org_wide_i = 1'b1, opc_done_i = 1'b0, rd_go_i = 1'b0;
   logic        busy_i = 1'b0, bsy_en_i = 1'b0;
   logic [15:0] rd_word_i;
   logic        dout_o, dout_oe_o, word_adv_o;
   int          idx = 0;
   int          n_checks = 0, n_fail = 0;
   bit          done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] word_at(int i);
      return 16'hA5C3 ^ 16'(i * 16'h1357);
   endfunction

   assign rd_word_i = word_at(idx);

   serial_dout_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .org_wide_i(org_wide_i),
      .opc_done_i(opc_done_i), .rd_go_i(rd_go_i), .rd_word_i(rd_word_i),
      .busy_i(busy_i), .bsy_en_i(bsy_en_i), .dout_o(dout_o),
      .dout_oe_o(dout_oe_o), .word_adv_o(word_adv_o)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Sends nwords words; drops chip select before the edge ending bit cut_bit
   // of the last word (cut_bit = word length - 1 means a full stream).
   task automatic t_read(bit wide, int nwords, int cut_bit, string req);
      int wl = wide ? 16 : 8;
      idx = 0;
      org_wide_i = wide;
      cs_i = 1'b1;
      rd_go_i = 1'b1;
      tick();
      rd_go_i = 1'b0;
      for (int w = 0; w < nwords; w++) begin
         logic [15:0] exp_w = word_at(w);
         for (int i = 0; i < wl; i++) begin
            check(dout_oe_o == 1'b1, req, dout_oe_o, 1);
            check(dout_o == exp_w[wl-1-i], req, dout_o, exp_w[wl-1-i]);
            if (i == 0) begin
               check(word_adv_o == 1'b1, "R5", word_adv_o, 1);
               idx++;
            end else begin
               check(word_adv_o == 1'b0, "R5", word_adv_o, 0);
            end
            if (w == nwords - 1 && i == cut_bit) cs_i = 1'b0;
            tick();
            if (w == nwords - 1 && i == cut_bit) begin
               check(dout_oe_o == 1'b0, "R4", dout_oe_o, 0);
               return;
            end
         end
      end
   endtask

   task automatic t_reset();
      check(dout_oe_o == 1'b0, "R1", dout_oe_o, 0);
      rst_n = 1'b1;
      tick();
      tick();
      check(dout_oe_o == 1'b0, "R1", dout_oe_o, 0);
   endtask

   task automatic t_busy_report();
      bsy_en_i = 1'b1;
      busy_i = 1'b1;
      tick();
      for (int k = 0; k < 5; k++) begin
         check(dout_oe_o && !dout_o, "R6", {dout_oe_o, dout_o}, 2'b10);
         tick();
      end
      busy_i = 1'b0;
      tick();
      for (int k = 0; k < 4; k++) begin
         check(dout_oe_o && dout_o, "R7", {dout_oe_o, dout_o}, 2'b11);
         tick();
      end
      opc_done_i = 1'b1;
      tick();
      opc_done_i = 1'b0;
      check(dout_oe_o == 1'b0, "R8", dout_oe_o, 0);
      tick();
      check(dout_oe_o == 1'b0, "R8", dout_oe_o, 0);
      bsy_en_i = 1'b0;
   endtask

   task automatic t_busy_ignored();
      bsy_en_i = 1'b0;
      busy_i = 1'b1;
      for (int k = 0; k < 6; k++) begin
         tick();
         check(dout_oe_o == 1'b0, "R9", dout_oe_o, 0);
      end
      busy_i = 1'b0;
      tick();
      check(dout_oe_o == 1'b0, "R9", dout_oe_o, 0);
   endtask

   task automatic t_ready_then_read();
      logic [15:0] exp_w;
      bsy_en_i = 1'b1;
      busy_i = 1'b1;
      tick();
      busy_i = 1'b0;
      tick();
      check(dout_oe_o && dout_o, "R7", {dout_oe_o, dout_o}, 2'b11);
      idx = 5;
      exp_w = word_at(5);
      org_wide_i = 1'b0;
      cs_i = 1'b1;
      opc_done_i = 1'b1;
      rd_go_i = 1'b1;
      tick();
      opc_done_i = 1'b0;
      rd_go_i = 1'b0;
      for (int i = 0; i < 8; i++) begin
         check(dout_oe_o && dout_o == exp_w[7-i], "R10", dout_o, exp_w[7-i]);
         if (i == 7) cs_i = 1'b0;
         tick();
      end
      check(dout_oe_o == 1'b0, "R4", dout_oe_o, 0);
      bsy_en_i = 1'b0;
   endtask

   initial begin
      tick();
      t_reset();
      t_read(1'b1, 1, 15, "R2");
      t_read(1'b0, 1, 7, "R3");
      t_read(1'b1, 3, 15, "R5");
      t_read(1'b1, 1, 5, "R4");
      t_read(1'b0, 2, 3, "R3");
      t_busy_report();
      t_busy_ignored();
      t_ready_then_read();
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule